// File: doc/BRIEF.md
# PCIe Receive Packet Header Splitter and Payload Realigner

This block sits behind a 128-bit receive stream that carries PCI Express transaction-layer packets. Each beat has four 32-bit dword lanes and is qualified by valid, start and end flags. On each start beat the block captures the header (3 or 4 dwords) into a header record. It then rebuilds the payload as a separate stream in which payload dword 0 always sits in the lowest lane.

Where the payload begins depends on the header size and on address bit 2. Depending on those two values, payload dword 0 may sit in the top lane of the start beat, in lane 0 of the next beat, or in lane 1 of the next beat. The block keeps the previous input beat and selects a 4-dword window across the previous and current beats. The header length field, not the input empty flag, decides where the payload ends and how many dwords the last output beat holds. When dwords are still held after the input end beat, one extra output beat is produced, and the input is stalled for that one cycle.

Top module: `tlpRealign`

## Requirements
- R1: One cycle after a start beat is accepted, hdrValid pulses for one cycle. hdrData holds the start beat with header dword 0 in bits [31:0]. hdrIs4Dw equals bit 29 of dword 0. For a 3-dword header, bits [127:96] of hdrData read zero.
- R2: A packet whose dword 0 has bit 30 clear produces a header record and no payload beats.
- R3: For a 3-dword header where bit 2 of dword 2 is set, payload dword 0 is taken from bits [127:96] of the start beat, and later dwords follow in ascending lane order over the next beats.
- R4: When the address bit 2 is clear, for either header size, payload dword 0 is taken from lane 0 of the beat after the start beat.
- R5: For a 4-dword header where bit 2 of dword 3 is set, payload dword 0 is taken from bits [63:32] of the beat after the start beat. Bits [31:0] of that beat are ignored.
- R6: Payload dword k of a packet appears in lane (k mod 4) of output beat k/4. plSop is high on that packet's first payload beat only, and plEop on its last only.
- R7: plCount is 4 on every payload beat except the end beat. On the end beat it is ((L-1) mod 4)+1, where L is bits [9:0] of dword 0 and a field of 0 means L = 1024.
- R8: If dwords remain after the input end beat, inReady is low for exactly one cycle, and the next cycle presents a payload end beat.
- R9: Synchronous active-high reset clears hdrValid and plValid and leaves inReady high.
- R10: Idle cycles (inValid low) between or inside packets do not change the payload or header output content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 128 | Receive beat, four dword lanes |
| inValid | input | 1 | Beat qualifier |
| inSop | input | 1 | First beat of a packet |
| inEop | input | 1 | Last beat of a packet |
| inReady | output | 1 | Low while an extra payload beat is being produced |
| hdrValid | output | 1 | Header record strobe |
| hdrData | output | 128 | Header dwords 0..3, ascending lanes |
| hdrIs4Dw | output | 1 | Header is 4 dwords |
| plValid | output | 1 | Payload beat strobe |
| plSop | output | 1 | First payload beat |
| plEop | output | 1 | Last payload beat |
| plCount | output | 3 | Valid dwords in this beat, 1 to 4 |
| plData | output | 128 | Realigned payload, dword 0 in bits [31:0] |

## Verification
The hardest state to reach is the extra trailing beat. It only arises when the payload start lane, together with a length whose residue leaves dwords behind, pushes data past the input end beat. A single-dword payload in the top lane of the start beat is the most extreme form. The bench sweeps all four combinations of header size and address bit 2 against payload lengths 1 to 9, and adds the 1024-dword encoding. This produces every residue in every lane offset, including start-and-end-in-one-beat packets. Idle gaps are placed inside packets at length-dependent positions, so stalls and bubbles land on different beats of the window.

// File: rtl/tlpRealignPkg.sv
package tlpRealignPkg;
  localparam int DWORD_W = 32;
  localparam int LANES = 4;
  localparam int BEAT_W = DWORD_W * LANES;
  localparam int LEN_W = 11;
  localparam int CNT_W = 3;
  localparam int SH_W = 3;

  typedef struct packed {
    logic capHdr;
    logic hdr4;
    logic loadPrev;
    logic emit;
    logic flush;
    logic sop;
    logic eop;
    logic [CNT_W-1:0] count;
    logic [SH_W-1:0] shift;
  } strobeT;
endpackage

// File: rtl/tlpRealignCtrl.sv
module tlpRealignCtrl
  import tlpRealignPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic inSop,
  input  logic inEop,
  input  logic [DWORD_W-1:0] hdrWord0,
  input  logic addrBitLo,
  input  logic addrBitHi,
  output logic inReady,
  output strobeT stb
);
  logic pendFlush, havePrev, firstOut;
  logic [LEN_W-1:0] rem, remAfter, lenNew;
  logic [SH_W-1:0] shReg, shNew;
  logic [CNT_W-1:0] take;
  logic accept, isSop, dataBeat, fmt4, hasPay, a2, emitData, emit;

  assign inReady = !pendFlush;
  assign accept = inValid && inReady;
  assign isSop = accept && inSop;
  assign dataBeat = accept && !inSop;
  assign fmt4 = hdrWord0[29];
  assign hasPay = hdrWord0[30];
  assign lenNew = {hdrWord0[9:0] == 10'd0, hdrWord0[9:0]};
  assign a2 = fmt4 ? addrBitHi : addrBitLo;
  assign shNew = a2 ? (fmt4 ? SH_W'(1) : SH_W'(3)) : SH_W'(4);

  assign emitData = dataBeat && (rem != '0) && (shReg != SH_W'(1) || havePrev);
  assign emit = emitData || pendFlush;
  assign take = (rem > LEN_W'(4)) ? CNT_W'(4) : rem[CNT_W-1:0];
  assign remAfter = rem - (emit ? LEN_W'(take) : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pendFlush <= 1'b0;
      havePrev <= 1'b0;
      firstOut <= 1'b0;
      rem <= '0;
      shReg <= SH_W'(4);
    end else if (isSop) begin
      shReg <= shNew;
      rem <= hasPay ? lenNew : '0;
      havePrev <= (shNew == SH_W'(3));
      firstOut <= 1'b1;
      pendFlush <= inEop && hasPay && (shNew == SH_W'(3));
    end else begin
      if (emit) begin
        rem <= remAfter;
        firstOut <= 1'b0;
      end
      if (dataBeat) havePrev <= 1'b1;
      if (pendFlush) pendFlush <= 1'b0;
      else if (dataBeat && inEop) pendFlush <= (remAfter != '0);
    end
  end

  always_comb begin
    stb.capHdr = isSop;
    stb.hdr4 = fmt4;
    stb.loadPrev = accept;
    stb.emit = emit;
    stb.flush = pendFlush;
    stb.sop = firstOut;
    stb.eop = (rem <= LEN_W'(4));
    stb.count = take;
    stb.shift = shReg;
  end
endmodule

// File: rtl/tlpRealignData.sv
module tlpRealignData
  import tlpRealignPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic [BEAT_W-1:0] inData,
  input  strobeT stb,
  output logic hdrValid,
  output logic [BEAT_W-1:0] hdrData,
  output logic hdrIs4Dw,
  output logic plValid,
  output logic plSop,
  output logic plEop,
  output logic [CNT_W-1:0] plCount,
  output logic [BEAT_W-1:0] plData
);
  localparam int WIN_W = 2 * BEAT_W;
  logic [BEAT_W-1:0] prevBeat;
  logic [WIN_W-1:0] window, shifted;

  assign window = stb.flush ? {{BEAT_W{1'b0}}, prevBeat} : {inData, prevBeat};
  assign shifted = window >> {stb.shift, 5'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      hdrValid <= 1'b0;
      plValid <= 1'b0;
      prevBeat <= '0;
    end else begin
      hdrValid <= stb.capHdr;
      plValid <= stb.emit;
      if (stb.loadPrev) prevBeat <= inData;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.capHdr) begin
      hdrData <= stb.hdr4 ? inData : {{DWORD_W{1'b0}}, inData[BEAT_W-DWORD_W-1:0]};
      hdrIs4Dw <= stb.hdr4;
    end
    if (stb.emit) begin
      plData <= shifted[BEAT_W-1:0];
      plSop <= stb.sop;
      plEop <= stb.eop;
      plCount <= stb.eop ? stb.count : CNT_W'(LANES);
    end
  end
endmodule

// File: rtl/tlpRealign.sv
module tlpRealign
  import tlpRealignPkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic [127:0] inData,
  input  logic inValid,
  input  logic inSop,
  input  logic inEop,
  output logic inReady,
  output logic hdrValid,
  output logic [127:0] hdrData,
  output logic hdrIs4Dw,
  output logic plValid,
  output logic plSop,
  output logic plEop,
  output logic [2:0] plCount,
  output logic [127:0] plData
);
  strobeT stb;

  tlpRealignCtrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .hdrWord0(inData[31:0]), .addrBitLo(inData[66]), .addrBitHi(inData[98]),
    .inReady(inReady), .stb(stb)
  );

  tlpRealignData u_data (
    .clk(clk), .rst(rst), .inData(inData), .stb(stb),
    .hdrValid(hdrValid), .hdrData(hdrData), .hdrIs4Dw(hdrIs4Dw),
    .plValid(plValid), .plSop(plSop), .plEop(plEop),
    .plCount(plCount), .plData(plData)
  );
endmodule

module tlpRealignChk (
  input logic clk,
  input logic rst,
  input logic [127:0] inData,
  input logic inValid,
  input logic inSop,
  input logic inEop,
  input logic inReady,
  input logic hdrValid,
  input logic [127:0] hdrData,
  input logic hdrIs4Dw,
  input logic plValid,
  input logic plSop,
  input logic plEop,
  input logic [2:0] plCount,
  input logic [127:0] plData
);
  // R8
  flush_eop_chk: assert property (@(posedge clk) disable iff (rst)
    !inReady |=> plValid && plEop);
  // R8
  single_stall_chk: assert property (@(posedge clk) disable iff (rst)
    !inReady |=> inReady);
  // R7
  end_count_chk: assert property (@(posedge clk) disable iff (rst)
    plValid && plEop |-> plCount >= 3'd1 && plCount <= 3'd4);
  // R7
  mid_count_chk: assert property (@(posedge clk) disable iff (rst)
    plValid && !plEop |-> plCount == 3'd4);
  // R1
  hdr3_mask_chk: assert property (@(posedge clk) disable iff (rst)
    hdrValid && !hdrIs4Dw |-> hdrData[127:96] == 32'd0);
  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !plValid && !hdrValid && inReady);
  // R6
  sop_apart_chk: assert property (@(posedge clk) disable iff (rst)
    plValid && plSop |-> !hdrValid);
endmodule

bind tlpRealign tlpRealignChk u_chk (.*);

// File: tb/sim_tlpRealign.sv
module sim_tlpRealign;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [127:0] inData = '0;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic inReady, hdrValid, hdrIs4Dw, plValid, plSop, plEop;
  logic [127:0] hdrData, plData;
  logic [2:0] plCount;

  int checks = 0, errors = 0, curRem = 0;
  bit done = 0, lastStall = 0;
  int expLenQ[$];
  logic [31:0] expPlQ[$];
  logic [31:0] expHdrQ[$];
  bit expHdr4Q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlpRealign u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // header monitor (R1, R2) and payload monitor (R3-R8, R10)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (lastStall)
        check(plValid && plEop, "R8 extra beat after stall", {plValid, plEop}, 2'b11);
      if (!inReady)
        check(!lastStall, "R8 stall longer than one cycle", 1, 0);
      lastStall = !inReady;
      if (hdrValid) begin
        if (expHdrQ.size() == 0) check(0, "R1 unexpected header", hdrData, 0);
        else begin
          logic [31:0] e0;
          bit e4;
          e0 = expHdrQ.pop_front();
          e4 = expHdr4Q.pop_front();
          check(hdrData[31:0] == e0 && hdrIs4Dw == e4 && (e4 || hdrData[127:96] == 0),
                "R1 header record", {hdrIs4Dw, hdrData[127:96], hdrData[31:0]}, {e4, 32'd0, e0});
        end
      end
      if (plValid) begin
        bit expSop;
        int n;
        bit ok;
        logic [127:0] expData;
        expSop = 0;
        if (curRem == 0) begin
          if (expLenQ.size() == 0) begin
            check(0, "R2 unexpected payload beat", plData, 0);
            curRem = 1;
          end else curRem = expLenQ.pop_front();
          expSop = 1;
        end
        n = curRem > 4 ? 4 : curRem;
        expData = plData;
        for (int i = 0; i < n; i++)
          expData[i*32 +: 32] = (expPlQ.size() > 0) ? expPlQ.pop_front() : 32'hx;
        ok = (plData === expData);
        check(ok, "R3 R4 R5 R6 R10 payload lanes", plData, expData);
        check(plSop == expSop && plEop == (curRem <= 4) && plCount == 3'(n),
              "R6 R7 sop/eop/count", {plSop, plEop, plCount}, {expSop, curRem <= 4, 3'(n)});
        curRem -= n;
      end
    end
  end

  task automatic sendBeat(input logic [127:0] d, input bit s, input bit e);
    bit acc;
    @(negedge clk);
    inData = d; inValid = 1'b1; inSop = s; inEop = e;
    acc = inReady;
    @(posedge clk);
    while (!acc) begin
      @(negedge clk);
      acc = inReady;
      @(posedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    @(posedge clk);
  endtask

  task automatic sendPacket(input int pkt, input bit fmt4, input bit a2, input bit hasPay, input int len);
    int hlen, p, total, beats;
    logic [31:0] hdr [4];
    logic [9:0] lenField;
    lenField = 10'(len);
    hlen = fmt4 ? 4 : 3;
    p = fmt4 ? (a2 ? 5 : 4) : (a2 ? 3 : 4);
    hdr[0] = {1'b0, hasPay, fmt4, 19'd0, lenField};
    hdr[1] = 32'h1111_0000 | 32'(pkt);
    hdr[2] = fmt4 ? (32'h2222_0000 | {29'd0, !a2, 2'd0}) : (32'h4000_0000 | {29'd0, a2, 2'd0});
    hdr[3] = 32'h8000_0000 | {29'd0, a2, 2'd0};
    expHdrQ.push_back(hdr[0]);
    expHdr4Q.push_back(fmt4);
    total = hasPay ? p + len : hlen;
    beats = (total + 3) / 4;
    if (hasPay) begin
      expLenQ.push_back(len);
      for (int k = 0; k < len; k++) expPlQ.push_back({pkt[11:0], 20'(k)});
    end
    for (int b = 0; b < beats; b++) begin
      logic [127:0] d;
      for (int l = 0; l < 4; l++) begin
        int pos;
        pos = b * 4 + l;
        if (pos < hlen) d[l*32 +: 32] = hdr[pos];
        else if (hasPay && pos >= p && pos < p + len) d[l*32 +: 32] = {pkt[11:0], 20'(pos - p)};
        else d[l*32 +: 32] = 32'hDEAD_0000 | 32'(pos);
      end
      sendBeat(d, b == 0, b == beats - 1);
      if (((b + len + pkt) % 3) == 0) idle();  // R10 bubbles
    end
    idle();
  endtask

  initial begin
    int pkt;
    pkt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(!plValid && !hdrValid && inReady, "R9 reset state", {plValid, hdrValid, inReady}, 3'b001);
    for (int hc = 0; hc < 4; hc++) begin
      for (int len = 1; len <= 9; len++) begin
        sendPacket(pkt, hc[1], hc[0], 1'b1, len);
        pkt++;
      end
      sendPacket(pkt, hc[1], hc[0], 1'b0, 5);   // R2 no payload
      pkt++;
      sendPacket(pkt, hc[1], hc[0], 1'b1, 1024); // R7 length field 0
      pkt++;
    end
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(expLenQ.size() == 0 && expPlQ.size() == 0 && curRem == 0, "R2 R6 payload fully delivered",
          expPlQ.size(), 0);
    check(expHdrQ.size() == 0, "R1 all headers delivered", expHdrQ.size(), 0);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      check(0, "R8 watchdog expired", 0, 1);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule